// File: doc/BRIEF.md
# Key-Protected Dual-Bank Flash Mode Control Register

This block is a single 32-bit control word on a simple register bus. It switches a flash subsystem into a dual-bank mode and chooses which of two flash macros answers accesses that fall inside a fixed dual-bank address window. Software changes the word with one full-word write. The upper half of that write must carry an unlock key, and the write must come from user privilege.

Two rules make the setting hard to change by accident. First, the remap bit can only be set by the same write that sets the enable bit. Second, once the enable bit is 1, the register refuses every later write until reset. A refused write leaves the register unchanged and produces a one-cycle pulse.

The register outputs feed a small window decoder. For a flash address inside the window, that decoder reports a hit and names the serving macro. A remap value of 0 selects macro 1, and a remap value of 1 selects macro 0.

Top module: `dualbank_ctl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `dual_en`, `remap_sel`, `win_bank_sel`, `win_hit`, `macro_id` and `wr_ignored` are 0, and the register reads as 0.
- R2: A read at offset `REG_OFFSET` (default 0x10) returns bit 0 = enable and bit 1 = remap. Bits 31:2, which include the key field 31:16, read as 0. Any other offset reads as 0.
- R3: A write to the register is accepted only if bits 31:16 equal 0xEACC. Any other key value leaves the register unchanged.
- R4: A write is accepted only if `bus_be` is 4'b1111. Any narrower strobe pattern leaves the register unchanged.
- R5: A write is accepted only if `priv_user` is 1. With `priv_user` at 0 the write leaves the register unchanged.
- R6: A write whose bit 1 is 1 and bit 0 is 0 leaves the register unchanged, even when the key is correct.
- R7: Once `dual_en` is 1, every later write leaves the register unchanged until `rst_n` goes low.
- R8: An accepted write loads bit 0 into enable and bit 1 into remap. The new values are visible at the ports and on the read data in the cycle after the write. Bits 15:2 of the write have no effect.
- R9: A refused write to `REG_OFFSET` raises `wr_ignored` for exactly the cycle after the write. A write to any other offset changes nothing and raises no pulse.
- R10: `win_bank_sel` equals the remap bit while enable is 1, and is 0 while enable is 0.
- R11: `win_hit` is 1 exactly when enable is 1 and `flash_addr` lies in [`WIN_BASE`, `WIN_BASE`+`WIN_SIZE`) (default 0x800 to 0xBFF). While `win_hit` is 1, `macro_id` is 1 for remap 0 and 0 for remap 1. Otherwise `macro_id` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte strobes |
| bus_wdata | input | 32 | Write data (key, reserved, control bits) |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| priv_user | input | 1 | 1 when the access comes from user mode |
| flash_addr | input | FADDR_W | Flash address being decoded |
| dual_en | output | 1 | Dual-bank mode enable |
| remap_sel | output | 1 | Remap bit |
| win_bank_sel | output | 1 | Bank select for the dual-bank window |
| win_hit | output | 1 | Address lies in the active window |
| macro_id | output | 1 | Macro that serves a window hit |
| wr_ignored | output | 1 | One-cycle pulse after a refused write |

## Verification
The block holds only two state bits, so any corruption shows up on the read data and on `dual_en`, `remap_sel` and `win_bank_sel` in the cycle after the faulty write. Two faults are easy to miss because the port values look plausible: a lock that fails to hold, and remap being set without enable. The first appears as the enable bit falling without a reset. The second appears as remap reading 1 while enable reads 0. A wrong qualifier decision appears in the same cycle on `wr_ignored`, so every write in the sweep is scored on its pulse as well as its resulting state. The window decoder is combinational, so a wrong hit or macro choice appears on the same address, and every flash address is swept in each reachable state.

// File: rtl/dualbank_pkg.sv
`timescale 1ns/1ps
package dualbank_pkg;
  localparam int WORD_W   = 32;
  localparam int KEY_W    = 16;
  localparam int STRB_W   = WORD_W / 8;
  localparam int RSVD_W   = WORD_W - KEY_W - 2;

  typedef struct packed {
    logic remap;
    logic en;
  } ctl_t;

  typedef struct packed {
    logic [KEY_W-1:0]  key;
    logic [RSVD_W-1:0] rsvd;
    ctl_t              ctl;
  } wword_t;
endpackage

// File: rtl/dualbank_wr_qual.sv
`timescale 1ns/1ps
module dualbank_wr_qual
  import dualbank_pkg::*;
#(
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hEACC
) (
  input  logic              hit_wr,
  input  logic [STRB_W-1:0] be,
  input  logic [KEY_W-1:0]  key,
  input  ctl_t              req,
  input  logic              priv_user,
  input  logic              locked,
  output logic              accept,
  output logic              reject
);
  localparam logic [STRB_W-1:0] FULL_STRB = {STRB_W{1'b1}};

  logic key_ok, width_ok, combo_ok, allowed;

  always_comb begin
    key_ok   = (key == UNLOCK_KEY);
    width_ok = (be == FULL_STRB);
    combo_ok = !(req.remap && !req.en);
    allowed  = key_ok && width_ok && combo_ok && priv_user && !locked;
    accept   = hit_wr && allowed;
    reject   = hit_wr && !allowed;
  end
endmodule

// File: rtl/dualbank_ctl_reg.sv
`timescale 1ns/1ps
module dualbank_ctl_reg
  import dualbank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic reject,
  input  ctl_t wr_val,
  output ctl_t ctl_q,
  output logic ign_q
);
  ctl_t ctl_d;
  logic ctl_ce;
  logic ign_d;

  always_comb begin
    ctl_ce = accept;
    ctl_d  = wr_val;
    ign_d  = reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_ce) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ign_q <= 1'b0;
    end else begin
      ign_q <= ign_d;
    end
  end
endmodule

// File: rtl/dualbank_win_map.sv
`timescale 1ns/1ps
module dualbank_win_map
  import dualbank_pkg::*;
#(
  parameter int FADDR_W  = 12,
  parameter int WIN_BASE = 2048,
  parameter int WIN_SIZE = 1024
) (
  input  ctl_t               ctl,
  input  logic [FADDR_W-1:0] flash_addr,
  output logic               win_hit,
  output logic               macro_id,
  output logic               bank_sel
);
  localparam int EXT_W = FADDR_W + 2;
  localparam logic [EXT_W-1:0] WIN_LO = EXT_W'(WIN_BASE);
  localparam logic [EXT_W-1:0] WIN_HI = EXT_W'(WIN_BASE + WIN_SIZE);

  logic [EXT_W-1:0] addr_ext;
  logic             in_range;

  always_comb begin
    addr_ext = {2'b00, flash_addr};
    in_range = (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
    win_hit  = ctl.en && in_range;
    bank_sel = ctl.en && ctl.remap;
    macro_id = win_hit && !ctl.remap;
  end
endmodule

// File: rtl/dualbank_ctl.sv
`timescale 1ns/1ps
module dualbank_ctl
  import dualbank_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  REG_OFFSET = 8'h10,
  parameter logic [15:0] UNLOCK_KEY = 16'hEACC,
  parameter int          FADDR_W    = 12,
  parameter int          WIN_BASE   = 2048,
  parameter int          WIN_SIZE   = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               priv_user,
  input  logic [FADDR_W-1:0] flash_addr,
  output logic               dual_en,
  output logic               remap_sel,
  output logic               win_bank_sel,
  output logic               win_hit,
  output logic               macro_id,
  output logic               wr_ignored
);
  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

  wword_t wword;
  ctl_t   ctl_q;
  logic   sel, hit_wr, accept, reject;

  always_comb begin
    wword  = wword_t'(bus_wdata);
    sel    = (bus_addr == OFFS);
    hit_wr = sel && bus_wr;
  end

  dualbank_wr_qual #(.UNLOCK_KEY(UNLOCK_KEY)) u_qual (
    .hit_wr    (hit_wr),
    .be        (bus_be),
    .key       (wword.key),
    .req       (wword.ctl),
    .priv_user (priv_user),
    .locked    (ctl_q.en),
    .accept    (accept),
    .reject    (reject)
  );

  dualbank_ctl_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .reject (reject),
    .wr_val (wword.ctl),
    .ctl_q  (ctl_q),
    .ign_q  (wr_ignored)
  );

  dualbank_win_map #(
    .FADDR_W  (FADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE)
  ) u_win (
    .ctl        (ctl_q),
    .flash_addr (flash_addr),
    .win_hit    (win_hit),
    .macro_id   (macro_id),
    .bank_sel   (win_bank_sel)
  );

  always_comb begin
    dual_en   = ctl_q.en;
    remap_sel = ctl_q.remap;
    bus_rdata = '0;
    if (sel) bus_rdata[1:0] = {ctl_q.remap, ctl_q.en};
  end
endmodule

// File: rtl/dualbank_ctl_chk.sv
`timescale 1ns/1ps
module dualbank_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [3:0] bus_be,
  input logic       priv_user,
  input logic       dual_en,
  input logic       remap_sel,
  input logic       win_bank_sel,
  input logic       win_hit,
  input logic       wr_ignored
);
  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dual_en |=> dual_en);

  // R6
  remap_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_en |-> !remap_sel);

  // R5
  priv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !priv_user) |=> $stable({dual_en, remap_sel}));

  // R4
  strobe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_be != 4'hF) |=> $stable({dual_en, remap_sel}));

  // R9
  ignored_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |-> $stable({dual_en, remap_sel}));

  // R10
  bank_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_en |-> !win_bank_sel);

  // R11
  hit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_en |-> !win_hit);
endmodule

bind dualbank_ctl dualbank_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_be       (bus_be),
  .priv_user    (priv_user),
  .dual_en      (dual_en),
  .remap_sel    (remap_sel),
  .win_bank_sel (win_bank_sel),
  .win_hit      (win_hit),
  .wr_ignored   (wr_ignored)
);

// File: tb/dualbank_ctl_tb.sv
`timescale 1ns/1ps
module dualbank_ctl_tb;
  localparam logic [7:0] REG = 8'h10;
  localparam logic [15:0] KEY = 16'hEACC;

  logic        clk, rst_n, bus_wr, priv_user;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [11:0] flash_addr;
  logic        dual_en, remap_sel, win_bank_sel, win_hit, macro_id, wr_ignored;

  int checks = 0, errors = 0;
  bit done = 0;
  logic exp_en, exp_rm;

  dualbank_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .priv_user(priv_user), .flash_addr(flash_addr), .dual_en(dual_en),
    .remap_sel(remap_sel), .win_bank_sel(win_bank_sel), .win_hit(win_hit),
    .macro_id(macro_id), .wr_ignored(wr_ignored)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk(bus_rdata == {30'b0, exp_rm, exp_en}, tag, bus_rdata, {30'b0, exp_rm, exp_en});
    chk({dual_en, remap_sel, win_bank_sel} == {exp_en, exp_rm, exp_en & exp_rm},
        tag, {dual_en, remap_sel, win_bank_sel}, {exp_en, exp_rm, exp_en & exp_rm});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    exp_en = 0; exp_rm = 0;
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d,
                       input logic pv, input string tag);
    bit acc, ign;
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; priv_user = pv; bus_wr = 1;
    acc = (a == REG) && be == 4'hF && pv && d[31:16] == KEY && !exp_en && !(d[1] && !d[0]);
    ign = (a == REG) && !acc;
    @(negedge clk);
    bus_wr = 0; bus_addr = REG;
    if (acc) begin exp_en = d[0]; exp_rm = d[1]; end
    check_state(tag);
    chk(wr_ignored == ign, {tag, "/R9"}, {31'b0, wr_ignored}, {31'b0, ign});
    @(negedge clk);
    chk(wr_ignored == 1'b0, "R9 pulse width", {31'b0, wr_ignored}, 32'b0);
  endtask

  initial begin
    rst_n = 0; bus_wr = 0; bus_addr = REG; bus_be = 0; bus_wdata = 0;
    priv_user = 0; flash_addr = 0; exp_en = 0; exp_rm = 0;
    repeat (3) @(negedge clk);
    chk({dual_en, remap_sel, win_bank_sel, win_hit, macro_id, wr_ignored} == 6'b0,
        "R1 in reset", {26'b0, dual_en, remap_sel, win_bank_sel, win_hit, macro_id, wr_ignored}, 0);
    rst_n = 1;
    @(negedge clk);
    check_state("R1 after reset");
    chk(wr_ignored == 0, "R1 ign", {31'b0, wr_ignored}, 0);

    // sweep of privilege, strobes, key and control combination from reset
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < 16; b++)
        for (int k = 0; k < 3; k++)
          for (int c = 0; c < 4; c++) begin
            logic [15:0] kv;
            string tag;
            kv = (k == 0) ? KEY : (k == 1) ? 16'hEACD : 16'h0000;
            if (p == 0) tag = "R5";
            else if (b != 15) tag = "R4";
            else if (k != 0) tag = "R3";
            else if (c == 2) tag = "R6";
            else tag = "R8";
            do_reset();
            do_wr(REG, b[3:0], {kv, 14'h1555, c[1:0]}, p[0], tag);
          end

    // lock: every write refused once enabled
    for (int s = 0; s < 2; s++) begin
      do_reset();
      do_wr(REG, 4'hF, {KEY, 14'h0, s[0], 1'b1}, 1'b1, "R8 enable");
      for (int c = 0; c < 4; c++) begin
        do_wr(REG, 4'hF, {KEY, 14'h0, c[1:0]}, 1'b1, "R7");
        chk(dual_en == 1'b1, "R7 held", {31'b0, dual_en}, 1);
      end
    end
    do_reset();
    check_state("R7 released by reset");
    do_wr(REG, 4'hF, {KEY, 14'h0, 2'b01}, 1'b1, "R7 relock");

    // other offsets: no change, no pulse, read zero
    do_reset();
    do_wr(8'h14, 4'hF, {KEY, 14'h0, 2'b11}, 1'b1, "R9 other offset");
    do_wr(REG, 4'hF, {KEY, 14'h0, 2'b11}, 1'b1, "R8 set both");
    @(negedge clk); bus_addr = 8'h14; #1;
    chk(bus_rdata == 0, "R2 other offset read", bus_rdata, 0);
    bus_addr = REG;

    // window map sweep in each reachable state
    for (int st = 0; st < 3; st++) begin
      do_reset();
      if (st == 1) do_wr(REG, 4'hF, {KEY, 14'h0, 2'b01}, 1'b1, "R8 en");
      if (st == 2) do_wr(REG, 4'hF, {KEY, 14'h0, 2'b11}, 1'b1, "R8 en+rm");
      for (int a = 0; a < 4096; a++) begin
        bit eh, em;
        flash_addr = a[11:0]; #0.1;
        eh = exp_en && a >= 2048 && a < 3072;
        em = eh && !exp_rm;
        chk({win_hit, macro_id} == {eh, em}, "R11", {30'b0, win_hit, macro_id}, {30'b0, eh, em});
        if (a == 0)
          chk(win_bank_sel == (exp_en & exp_rm), "R10", {31'b0, win_bank_sel}, {31'b0, exp_en & exp_rm});
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule